// File: doc/BRIEF.md
# Bitonic Sorting Network

This block sorts a fixed-size set of words in a single combinational pass. A set of `N` words of `M` bits each arrives packed on one input bus, and the same words leave on one output bus, placed in order. Nothing inside is clocked. The output settles as soon as the compare-and-swap columns have propagated. The design is a fixed bitonic merge network. Every column holds `N/2` comparator-plus-multiplexer cells. There are `log2(N)` merge phases, and the whole network has `log2(N)*(log2(N)+1)/2` columns. The comparator count therefore grows as `N*log²N`.

Two parameters are fixed at elaboration. `SIGNED_CMP` chooses between unsigned magnitude order and two's-complement order. `DESCEND` chooses the sort direction, and ascending is the default. The block is intended for places where a small, fixed-size set of keys must be ordered in zero cycles: picking the top few candidates, median filters, and priority selection. The surrounding logic registers the inputs and outputs as its own timing requires. Because the data path has no clock, it carries no valid/ready handshake. A caller that streams vectors through the block keeps its own valid bit alongside the data, and that bit passes the block with no delay.

Top module: `bitonic_sorter`

## Requirements
- R1: The block is purely combinational. Word `w` of either bus sits at bits `[w*M +: M]`, and word 0 is the lowest. The output follows a new input vector within the same clock period, and an all-zero input gives an all-zero output.
- R2: With `DESCEND = 0` (the default), output word 0 holds the smallest value, and values do not decrease as the word index rises.
- R3: With `DESCEND = 1`, output word 0 holds the largest value, and values do not increase as the word index rises.
- R4: With `SIGNED_CMP = 0`, words compare as unsigned numbers from 0 to 2^M-1. For example, 8'h80 ranks above 8'h7F.
- R5: With `SIGNED_CMP = 1`, words compare as two's-complement numbers. For example, with M = 3, 3'b100 (-4) is the smallest value and 3'b011 (+3) is the largest.
- R6: The output holds exactly the input values as a multiset, and duplicates keep their count. Among equal values, the block makes no guarantee about which input goes to which position.
- R7: Input that is already sorted, input that is sorted in reverse, and input whose words are all equal all come out correctly ordered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_words | input | N*M | Unsorted words, word w at bits [w*M +: M] |
| out_words | output | N*M | The same words in the chosen order, same packing |

## Verification
Two functions can act on the same vector at once: the handling of duplicate keys, and the reordering of keys that straddle the sign boundary. A vector that holds both a repeated value and values on each side of zero exercises the signed comparison and the preservation of the multiset together. An exhaustive sweep of every 4-word, 3-bit input, in both directions with signed comparison, covers every such mix. Each result is judged against an insertion sort computed in the bench. Wider 8-word, 8-bit instances take pseudo-random and directed vectors, which check unsigned order, duplicates and pre-ordered inputs.

// File: rtl/bitonic_pkg.sv
package bitonic_pkg;

  // Number of compare-exchange columns for a network of 2**lg inputs.
  function automatic int column_count(input int lg);
    return (lg * (lg + 1)) / 2;
  endfunction

  // Index of the first column belonging to merge phase ph (1-based).
  function automatic int phase_base(input int ph);
    return ((ph - 1) * ph) / 2;
  endfunction

  // Lower index of pair p in a column whose partner distance is 2**dl.
  function automatic int pair_low(input int p, input int dl);
    return ((p >> dl) << (dl + 1)) | (p & ((1 << dl) - 1));
  endfunction

endpackage

// File: rtl/bitonic_cas.sv
module bitonic_cas #(
  parameter int M          = 8,
  parameter bit SIGNED_CMP = 1'b0,
  parameter bit ASCEND     = 1'b1
) (
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic [M-1:0] lo_out,
  output logic [M-1:0] hi_out
);

  logic a_above;
  logic b_above;
  logic swap;

  generate
    if (SIGNED_CMP) begin : g_signed
      assign a_above = $signed(a_in) > $signed(b_in);
      assign b_above = $signed(b_in) > $signed(a_in);
    end else begin : g_unsigned
      assign a_above = a_in > b_in;
      assign b_above = b_in > a_in;
    end
  endgenerate

  // Ascending cells push the larger word up; descending ones push it down.
  assign swap   = ASCEND ? a_above : b_above;
  assign lo_out = swap ? b_in : a_in;
  assign hi_out = swap ? a_in : b_in;

endmodule

// File: rtl/bitonic_column.sv
module bitonic_column
  import bitonic_pkg::*;
#(
  parameter int N          = 8,
  parameter int M          = 8,
  parameter bit SIGNED_CMP = 1'b0,
  parameter bit DESCEND    = 1'b0,
  parameter int PHASE      = 1,
  parameter int DIST_LOG   = 0
) (
  input  logic [N*M-1:0] col_in,
  output logic [N*M-1:0] col_out
);

  localparam int PAIRS = N / 2;
  localparam int DIST  = 1 << DIST_LOG;

  generate
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      localparam int LO = pair_low(p, DIST_LOG);
      localparam int HI = LO + DIST;
      // Blocks of 2**PHASE alternate direction; in the last phase every
      // index shares bit PHASE = 0, so the global direction rules.
      localparam bit UP = (((LO >> PHASE) & 1) == 0) ^ DESCEND;

      bitonic_cas #(
        .M(M),
        .SIGNED_CMP(SIGNED_CMP),
        .ASCEND(UP)
      ) u_cas (
        .a_in  (col_in[LO*M +: M]),
        .b_in  (col_in[HI*M +: M]),
        .lo_out(col_out[LO*M +: M]),
        .hi_out(col_out[HI*M +: M])
      );
    end
  endgenerate

endmodule

// File: rtl/bitonic_sorter.sv
module bitonic_sorter
  import bitonic_pkg::*;
#(
  parameter int N          = 8,
  parameter int M          = 8,
  parameter bit SIGNED_CMP = 1'b0,
  parameter bit DESCEND    = 1'b0
) (
  input  logic [N*M-1:0] in_words,
  output logic [N*M-1:0] out_words
);

  localparam int LG   = $clog2(N);
  localparam int COLS = column_count(LG);

  generate
    if (N < 2 || (1 << LG) != N) begin : g_bad_size
      $error("bitonic_sorter: N must be a power of two and at least 2");
    end
  endgenerate

  logic [N*M-1:0] lane [0:COLS];

  assign lane[0] = in_words;

  generate
    for (genvar ph = 1; ph <= LG; ph++) begin : g_phase
      for (genvar t = 0; t < ph; t++) begin : g_col
        localparam int IDX = phase_base(ph) + t;
        bitonic_column #(
          .N(N),
          .M(M),
          .SIGNED_CMP(SIGNED_CMP),
          .DESCEND(DESCEND),
          .PHASE(ph),
          .DIST_LOG(ph - 1 - t)
        ) u_col (
          .col_in (lane[IDX]),
          .col_out(lane[IDX+1])
        );
      end
    end
  endgenerate

  assign out_words = lane[COLS];

endmodule

// File: rtl/bitonic_sorter_chk.sv
module bitonic_sorter_chk #(
  parameter int N          = 8,
  parameter int M          = 8,
  parameter bit SIGNED_CMP = 1'b0,
  parameter bit DESCEND    = 1'b0
) (
  input logic [N*M-1:0] in_words,
  input logic [N*M-1:0] out_words
);

  localparam int SW = M + $clog2(N) + 1;

  function automatic logic ranks_below(input logic [M-1:0] x, input logic [M-1:0] y);
    if (SIGNED_CMP) return $signed(x) < $signed(y);
    return x < y;
  endfunction

  logic          ordered;
  logic          extreme_ok;
  logic [SW-1:0] sum_in;
  logic [SW-1:0] sum_out;
  logic [M-1:0]  xor_in;
  logic [M-1:0]  xor_out;

  always_comb begin
    ordered    = 1'b1;
    extreme_ok = 1'b1;
    sum_in     = '0;
    sum_out    = '0;
    xor_in     = '0;
    xor_out    = '0;
    for (int w = 0; w < N; w++) begin
      sum_in  = sum_in  + SW'(in_words[w*M +: M]);
      sum_out = sum_out + SW'(out_words[w*M +: M]);
      xor_in  = xor_in  ^ in_words[w*M +: M];
      xor_out = xor_out ^ out_words[w*M +: M];
      if (DESCEND) begin
        if (ranks_below(out_words[M-1:0], in_words[w*M +: M])) extreme_ok = 1'b0;
      end else begin
        if (ranks_below(in_words[w*M +: M], out_words[M-1:0])) extreme_ok = 1'b0;
      end
    end
    for (int w = 1; w < N; w++) begin
      if (DESCEND) begin
        if (ranks_below(out_words[(w-1)*M +: M], out_words[w*M +: M])) ordered = 1'b0;
      end else begin
        if (ranks_below(out_words[w*M +: M], out_words[(w-1)*M +: M])) ordered = 1'b0;
      end
    end
  end

  always_comb begin
    // R2 R3
    order_chk: assert (ordered);
    // R2 R3
    extreme_chk: assert (extreme_ok);
    // R6
    sum_chk: assert (sum_in == sum_out);
    // R6
    parity_chk: assert (xor_in == xor_out);
  end

endmodule

bind bitonic_sorter bitonic_sorter_chk #(
  .N(N),
  .M(M),
  .SIGNED_CMP(SIGNED_CMP),
  .DESCEND(DESCEND)
) u_chk (
  .in_words (in_words),
  .out_words(out_words)
);

// File: tb/bitonic_sorter_tb.sv
module bitonic_sorter_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [63:0] w_in = '0;
  logic [11:0] s_in = '0;
  logic [63:0] w_asc, w_dsc;
  logic [11:0] s_asc, s_dsc;

  bitonic_sorter u_dut (.in_words(w_in), .out_words(w_asc));
  bitonic_sorter #(.DESCEND(1'b1)) u_dsc (.in_words(w_in), .out_words(w_dsc));
  bitonic_sorter #(.N(4), .M(3), .SIGNED_CMP(1'b1)) u_sa (.in_words(s_in), .out_words(s_asc));
  bitonic_sorter #(.N(4), .M(3), .SIGNED_CMP(1'b1), .DESCEND(1'b1)) u_sd (.in_words(s_in), .out_words(s_dsc));

  function automatic logic [63:0] ref_sort(input logic [63:0] v, input int n, input int m,
                                           input bit sgn, input bit desc);
    longint raw [8];
    longint key [8];
    logic [63:0] res;
    for (int i = 0; i < n; i++) begin
      raw[i] = longint'((v >> (i*m)) & ((64'd1 << m) - 64'd1));
      key[i] = (sgn && (((raw[i] >> (m-1)) & 1) == 1)) ? raw[i] - (longint'(1) << m) : raw[i];
    end
    for (int i = 1; i < n; i++) begin
      for (int j = i; j > 0; j--) begin
        if (desc ? (key[j-1] < key[j]) : (key[j-1] > key[j])) begin
          longint tk, tr;
          tk = key[j]; key[j] = key[j-1]; key[j-1] = tk;
          tr = raw[j]; raw[j] = raw[j-1]; raw[j-1] = tr;
        end
      end
    end
    res = '0;
    for (int i = 0; i < n; i++) res = res | (64'(raw[i]) << (i*m));
    return res;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wide_vec(input string tag, input logic [63:0] v);
    @(posedge clk);
    #1 w_in = v;
    @(negedge clk);
    check({tag, " asc"}, w_asc, ref_sort(v, 8, 8, 1'b0, 1'b0));
    check({tag, " desc"}, w_dsc, ref_sort(v, 8, 8, 1'b0, 1'b1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: zero input gives zero output
    @(negedge clk);
    check("R1 zero", w_asc, 64'd0);
    check("R1 zero small", {52'd0, s_asc}, 64'd0);

    // R1: output follows a new vector within the same period
    @(posedge clk);
    #1 w_in = 64'h0102_0304_0506_0708;
    @(negedge clk);
    check("R1 same-cycle", w_asc, 64'h0807_0605_0403_0201);

    // R4: 0x80 must rank above 0x7F unsigned
    @(posedge clk);
    #1 w_in = 64'h7F80_0000_0000_00FF;
    @(negedge clk);
    check("R4 unsigned", w_asc, 64'hFF80_7F00_0000_0000);

    // R6: duplicates keep their count
    wide_vec("R6 duplicates", 64'h0505_0303_0505_0303);
    wide_vec("R6 mixed dup", 64'hFF00_FF00_8080_0101);

    // R7: presorted, reversed, all equal
    wide_vec("R7 presorted", 64'hF0E0_D0C0_B0A0_9080);
    wide_vec("R7 reversed", 64'h0102_0304_0506_0708);
    wide_vec("R7 all equal", 64'hA5A5_A5A5_A5A5_A5A5);

    // R2 R3: pseudo-random vectors in both directions
    for (int k = 0; k < 2000; k++) begin
      logic [63:0] v;
      seed = seed * 32'd1664525 + 32'd1013904223;
      v[31:0] = seed;
      seed = seed * 32'd1664525 + 32'd1013904223;
      v[63:32] = seed;
      wide_vec("R2 R3 random", v);
    end

    // R5: exhaustive signed sweep, both directions
    for (int v = 0; v < 4096; v++) begin
      @(posedge clk);
      #1 s_in = v[11:0];
      @(negedge clk);
      check("R5 signed asc", {52'd0, s_asc}, ref_sort(64'(v), 4, 3, 1'b1, 1'b0));
      check("R5 signed desc", {52'd0, s_dsc}, ref_sort(64'(v), 4, 3, 1'b1, 1'b1));
    end

    // R5: explicit extremes -4 first and +3 last
    @(posedge clk);
    #1 s_in = {3'b011, 3'b000, 3'b100, 3'b111};
    @(negedge clk);
    check("R5 extremes", {52'd0, s_asc}, {52'd0, 3'b011, 3'b000, 3'b111, 3'b100});

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule